// File: doc/BRIEF.md
# Register Access Command Sequencer

This block is the command unit of an on-chip debug controller. A debugger reaches it through a small word-wide register window. That window holds a status word, a command word, one data word and sixteen instruction slots. Writing the command word asks the unit to move one value between the data word and a register of a halted core. The move goes through a request/response register port. The command can then start the core running the instruction slots. The core signals when it has finished running them, either by reaching a break instruction or by faulting.

The unit refuses work when the core is not halted, when the command kind is not supported, or when the access size does not match the data width. It flags a write that arrives while a command is still running. Each failure is kept as a 3-bit error code. The debugger clears that code by writing ones to it. While the code is nonzero, new commands are dropped. Register numbers follow the usual debug numbering: 0x1000 plus n selects general register n, and control registers keep their own numbers. The unit passes the number through unchanged.

Top module: `acmd_engine`

## Requirements
- R1: After reset the unit is idle and the error code is 0. Data word, command readback and every slot read 0, and no request or run pulse is driven. The status word (window address 0) reads error code in bits 2:0, busy in bit 8, slot count 16 in bits 20:16 and data word count 1 in bits 27:24.
- R2: The command word is at window address 1. Its fields are kind in bits 31:24, size in 22:20, post-increment in 19, run-after in 18, transfer in 17, direction in 16 (1 = write to the core) and register number in 15:0. A command with kind 0, size 2, transfer 1 and direction 0 issues one request with that register number and write 0. The returned value lands in the data word at window address 2.
- R3: With direction 1, the request carries write 1 and the current data word as write data. The data word itself is left unchanged.
- R4: A request, together with its register number and write data, stays asserted and unchanged until the port accepts it.
- R5: With post-increment 1, the register number read back at window address 1 is one higher after the transfer completes. With post-increment 0 it is unchanged.
- R6: With run-after 1, a single-cycle run pulse follows the transfer, or follows acceptance when transfer is 0. Busy stays 1 until the core reports completion. Completion with a fault sets error code 5.
- R7: A nonzero kind, or a size other than 2 while transfer is 1, sets error code 2 and issues nothing. The size field is ignored when transfer is 0.
- R8: An otherwise valid command while the core is not halted sets error code 4 and issues nothing.
- R9: A write to the command, the data word or a slot while busy sets error code 1 if the code was 0, and the write has no effect.
- R10: The error code is cleared bit by bit by writing ones to bits 2:0 of the status word. While the code is nonzero, a command write starts nothing and the code is kept.
- R11: Slots sit at window addresses 16 to 31. The core reads slot n through its slot index port, and the host reads it back at the same address.
- R12: A command with transfer 0 and run-after 0 completes at once, with no busy period, no request and no run pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Window access strobe |
| host_write | input | 1 | 1 = write access |
| host_addr | input | 5 | Window word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr |
| core_halted | input | 1 | Target core is halted |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 = write the core register |
| reg_req_regno | output | 16 | Register number |
| reg_req_wdata | output | 32 | Value to write |
| reg_rsp_valid | input | 1 | Register response valid |
| reg_rsp_rdata | input | 32 | Value read from the core |
| exec_start | output | 1 | Single-cycle request to run the slots |
| exec_done | input | 1 | Slot run finished |
| exec_fault | input | 1 | The finished run faulted |
| slot_idx | input | 4 | Slot index read by the core |
| slot_data | output | 32 | Slot contents for slot_idx |

## Verification
The bench targets the cases that ordering bugs break. A write that lands in the middle of a long slot run must be rejected: a sequencer that let it through would corrupt the data word or a slot, or would start a second command. A command sent while the error code is set must start nothing: a design that ignored the stickiness would issue a request. A partial clear must leave the other code bits alone, and a design using plain write semantics would wipe them. A size mismatch with transfer off must still run, while the same mismatch with transfer on must be refused. A design that always checked size would raise a false error here, and one that never checked it would move data. Random commands mix post-increment, read and write direction, halt loss and faults against a model of the core's registers. A wrong increment or a capture on a write shows up in the register readback or the data word.

// File: rtl/acmd_pkg.sv
package acmd_pkg;

    localparam int CMD_W   = 32;
    localparam int REGNO_W = 16;

    localparam int WIN_STATUS = 0;
    localparam int WIN_CMD    = 1;
    localparam int WIN_DATA   = 2;

    localparam logic [7:0] KIND_REG = 8'd0;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_HALT  = 3'd4;
    localparam logic [2:0] ERR_EXC   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RSP  = 3'd2,
        ST_GO   = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [7:0]         kind;
        logic [2:0]         size;
        logic               autoinc;
        logic               run;
        logic               xfer;
        logic               wr;
        logic [REGNO_W-1:0] regno;
    } cmd_t;

endpackage

// File: rtl/acmd_decode.sv
module acmd_decode
    import acmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CMD_W-1:0] word,
    output cmd_t             fields,
    output logic             bad
);
    localparam logic [2:0] SIZE_OK = 3'($clog2(DATA_W / 8));

    logic unused_bit23;
    assign unused_bit23 = word[23];

    assign fields.kind    = word[31:24];
    assign fields.size    = word[22:20];
    assign fields.autoinc = word[19];
    assign fields.run     = word[18];
    assign fields.xfer    = word[17];
    assign fields.wr      = word[16];
    assign fields.regno   = word[15:0];

    // size only matters when a transfer is requested
    assign bad = (fields.kind != KIND_REG) ||
                 (fields.xfer && (fields.size != SIZE_OK));

endmodule

// File: rtl/acmd_store.sv
module acmd_store #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_data_we,
    input  logic                       host_slot_we,
    input  logic [$clog2(SLOTS)-1:0]   host_slot_idx,
    input  logic [DATA_W-1:0]          host_wdata,
    input  logic                       cap_we,
    input  logic [DATA_W-1:0]          cap_data,
    input  logic [$clog2(SLOTS)-1:0]   core_slot_idx,
    output logic [DATA_W-1:0]          data_word,
    output logic [DATA_W-1:0]          host_slot_rd,
    output logic [DATA_W-1:0]          core_slot_rd
);
    localparam int IW = $clog2(SLOTS);

    typedef struct packed {
        logic [DATA_W-1:0]             data;
        logic [SLOTS-1:0][DATA_W-1:0]  slot;
    } store_t;

    store_t s_d, s_q;
    logic [SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign slot_hit[g] = host_slot_we && (host_slot_idx == IW'(g));
    end

    always_comb begin
        s_d = s_q;
        if (host_data_we) begin
            s_d.data = host_wdata;
        end else if (cap_we) begin
            s_d.data = cap_data;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_hit[i]) begin
                s_d.slot[i] = host_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_word    = s_q.data;
    assign host_slot_rd = s_q.slot[host_slot_idx];
    assign core_slot_rd = s_q.slot[core_slot_idx];

endmodule

// File: rtl/acmd_seq.sv
module acmd_seq
    import acmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  cmd_t               cmd_in,
    input  logic               cmd_bad,
    input  logic               stat_we,
    input  logic [2:0]         clr_mask,
    input  logic               blocked_we,
    input  logic               core_halted,
    input  logic               req_ready,
    input  logic               rsp_valid,
    input  logic               exec_done,
    input  logic               exec_fault,
    output logic               req_valid,
    output logic               req_write,
    output logic [REGNO_W-1:0] req_regno,
    output logic               exec_start,
    output logic               busy,
    output logic [2:0]         err,
    output cmd_t               cmd_q,
    output logic               cap_we
);
    typedef struct packed {
        seq_state_e st;
        logic [2:0] err;
        cmd_t       cmd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        cap_we = 1'b0;

        if (stat_we) begin
            s_d.err = s_q.err & ~clr_mask;
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_we && (s_q.err == ERR_NONE)) begin
                    s_d.cmd = cmd_in;
                    if (cmd_bad) begin
                        s_d.err = ERR_UNSUP;
                    end else if (!core_halted) begin
                        s_d.err = ERR_HALT;
                    end else if (cmd_in.xfer) begin
                        s_d.st = ST_REQ;
                    end else if (cmd_in.run) begin
                        s_d.st = ST_GO;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    s_d.st = ST_RSP;
                end
            end
            ST_RSP: begin
                if (rsp_valid) begin
                    cap_we = !s_q.cmd.wr;
                    if (s_q.cmd.autoinc) begin
                        s_d.cmd.regno = s_q.cmd.regno + REGNO_W'(1);
                    end
                    s_d.st = s_q.cmd.run ? ST_GO : ST_IDLE;
                end
            end
            ST_GO: begin
                s_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (exec_done) begin
                    if (exec_fault && (s_d.err == ERR_NONE)) begin
                        s_d.err = ERR_EXC;
                    end
                    s_d.st = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase

        if (blocked_we && (s_d.err == ERR_NONE)) begin
            s_d.err = ERR_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid  = (s_q.st == ST_REQ);
    assign req_write  = s_q.cmd.wr;
    assign req_regno  = s_q.cmd.regno;
    assign exec_start = (s_q.st == ST_GO);
    assign busy       = (s_q.st != ST_IDLE);
    assign err        = s_q.err;
    assign cmd_q      = s_q.cmd;

endmodule

// File: rtl/acmd_engine.sv
module acmd_engine
    import acmd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int SLOTS     = 16,
    parameter int ADDR_W    = 5,
    parameter int SLOT_BASE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_valid,
    input  logic                     host_write,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic                     core_halted,
    output logic                     reg_req_valid,
    input  logic                     reg_req_ready,
    output logic                     reg_req_write,
    output logic [15:0]              reg_req_regno,
    output logic [DATA_W-1:0]        reg_req_wdata,
    input  logic                     reg_rsp_valid,
    input  logic [DATA_W-1:0]        reg_rsp_rdata,
    output logic                     exec_start,
    input  logic                     exec_done,
    input  logic                     exec_fault,
    input  logic [$clog2(SLOTS)-1:0] slot_idx,
    output logic [DATA_W-1:0]        slot_data
);
    localparam int         IW         = $clog2(SLOTS);
    localparam logic [3:0] DATA_COUNT = 4'd1;
    localparam logic [4:0] SLOT_COUNT = 5'(SLOTS);

    logic          wr;
    logic          hit_stat, hit_cmd, hit_data, hit_slot;
    logic          busy_w;
    logic [2:0]    err_w;
    logic          cmd_we, data_we, slot_we, stat_we, blocked_we;
    cmd_t          cmd_fields, cmd_q;
    logic          cmd_bad;
    logic          cap_we;
    logic [IW-1:0] host_slot_idx;
    logic [DATA_W-1:0] data_word, host_slot_rd;
    logic [31:0]   status_word, cmd_readback;

    assign wr       = host_valid && host_write;
    assign hit_stat = (host_addr == ADDR_W'(WIN_STATUS));
    assign hit_cmd  = (host_addr == ADDR_W'(WIN_CMD));
    assign hit_data = (host_addr == ADDR_W'(WIN_DATA));
    assign hit_slot = (int'(host_addr) >= SLOT_BASE) &&
                      (int'(host_addr) <  SLOT_BASE + SLOTS);
    assign host_slot_idx = IW'(host_addr - ADDR_W'(SLOT_BASE));

    assign stat_we    = wr && hit_stat;
    assign cmd_we     = wr && hit_cmd  && !busy_w;
    assign data_we    = wr && hit_data && !busy_w;
    assign slot_we    = wr && hit_slot && !busy_w;
    assign blocked_we = wr && busy_w && (hit_cmd || hit_data || hit_slot);

    acmd_decode #(.DATA_W(DATA_W)) u_decode (
        .word   (host_wdata[CMD_W-1:0]),
        .fields (cmd_fields),
        .bad    (cmd_bad)
    );

    acmd_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_data_we  (data_we),
        .host_slot_we  (slot_we),
        .host_slot_idx (host_slot_idx),
        .host_wdata    (host_wdata),
        .cap_we        (cap_we),
        .cap_data      (reg_rsp_rdata),
        .core_slot_idx (slot_idx),
        .data_word     (data_word),
        .host_slot_rd  (host_slot_rd),
        .core_slot_rd  (slot_data)
    );

    acmd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_in      (cmd_fields),
        .cmd_bad     (cmd_bad),
        .stat_we     (stat_we),
        .clr_mask    (host_wdata[2:0]),
        .blocked_we  (blocked_we),
        .core_halted (core_halted),
        .req_ready   (reg_req_ready),
        .rsp_valid   (reg_rsp_valid),
        .exec_done   (exec_done),
        .exec_fault  (exec_fault),
        .req_valid   (reg_req_valid),
        .req_write   (reg_req_write),
        .req_regno   (reg_req_regno),
        .exec_start  (exec_start),
        .busy        (busy_w),
        .err         (err_w),
        .cmd_q       (cmd_q),
        .cap_we      (cap_we)
    );

    assign reg_req_wdata = data_word;

    assign status_word  = {4'b0, DATA_COUNT, 3'b0, SLOT_COUNT,
                           7'b0, busy_w, 5'b0, err_w};
    assign cmd_readback = {cmd_q.kind, 1'b0, cmd_q.size, cmd_q.autoinc,
                           cmd_q.run, cmd_q.xfer, cmd_q.wr, cmd_q.regno};

    always_comb begin
        host_rdata = '0;
        if (hit_stat) begin
            host_rdata = DATA_W'(status_word);
        end else if (hit_cmd) begin
            host_rdata = DATA_W'(cmd_readback);
        end else if (hit_data) begin
            host_rdata = data_word;
        end else if (hit_slot) begin
            host_rdata = host_slot_rd;
        end
    end

endmodule

// File: rtl/acmd_engine_chk.sv
module acmd_engine_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_halted,
    input logic              reg_req_valid,
    input logic              reg_req_ready,
    input logic [15:0]       reg_req_regno,
    input logic [DATA_W-1:0] reg_req_wdata,
    input logic              exec_start,
    input logic              host_valid,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic              busy,
    input logic [2:0]        err
);
    logic stat_write;
    assign stat_write = host_valid && host_write && (host_addr == '0);

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req_valid && !reg_req_ready |=>
        reg_req_valid && $stable(reg_req_regno) && $stable(reg_req_wdata));

    a_r8_halted_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_req_valid) |-> $past(core_halted));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err != 3'd0) && !stat_write |=> err == $past(err));

    a_r10_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(err) == 3'd0);

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    a_r6_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> busy);

endmodule

bind acmd_engine acmd_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_halted   (core_halted),
    .reg_req_valid (reg_req_valid),
    .reg_req_ready (reg_req_ready),
    .reg_req_regno (reg_req_regno),
    .reg_req_wdata (reg_req_wdata),
    .exec_start    (exec_start),
    .host_valid    (host_valid),
    .host_write    (host_write),
    .host_addr     (host_addr),
    .busy          (busy_w),
    .err           (err_w)
);

// File: tb/test_acmd_engine.sv
module test_acmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        core_halted = 1'b1;
    logic        reg_req_valid, reg_req_ready = 1'b0, reg_req_write;
    logic [15:0] reg_req_regno;
    logic [31:0] reg_req_wdata;
    logic        reg_rsp_valid = 1'b0;
    logic [31:0] reg_rsp_rdata = '0;
    logic        exec_start, exec_done = 1'b0, exec_fault = 1'b0;
    logic [3:0]  slot_idx = '0;
    logic [31:0] slot_data;

    always #2 clk = ~clk;

    acmd_engine i_acmd_engine (.*);

    int n_cmp = 0, n_bad = 0;
    int n_req = 0, n_exec = 0;
    logic [15:0] last_regno;
    logic        last_wr;
    logic [31:0] last_wdata;
    logic        fault_next = 1'b0;
    int          exec_delay = 0;
    logic [31:0] core_regs [256];
    logic [31:0] exp_regs  [256];
    bit          finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 500; k++) begin
            host_rd(5'd0, s);
            if (!s[8]) return;
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] kind, input logic [2:0] size,
                                       input logic ai, input logic run, input logic xf,
                                       input logic w, input logic [15:0] regno);
        return {kind, 1'b0, size, ai, run, xf, w, regno};
    endfunction

    // core register responder
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req_valid) begin
                logic [15:0] rn;
                int d;
                n_req++;
                rn = reg_req_regno;
                last_regno = reg_req_regno; last_wr = reg_req_write; last_wdata = reg_req_wdata;
                d = $urandom % 3;
                for (int k = 0; k < d; k++) begin
                    @(negedge clk);
                    chk("R4 request held", {15'b0, reg_req_valid, reg_req_regno}, {15'b0, 1'b1, rn});
                end
                reg_req_ready = 1'b1;
                @(negedge clk);
                reg_req_ready = 1'b0;
                if (last_wr) core_regs[last_regno[7:0]] = last_wdata;
                d = $urandom % 3;
                for (int k = 0; k < d; k++) @(negedge clk);
                reg_rsp_valid = 1'b1;
                reg_rsp_rdata = core_regs[last_regno[7:0]];
                @(negedge clk);
                reg_rsp_valid = 1'b0;
            end
        end
    end

    // slot runner
    initial begin
        forever begin
            @(negedge clk);
            if (exec_start) begin
                n_exec++;
                for (int k = 0; k < exec_delay + 1; k++) @(negedge clk);
                exec_done = 1'b1; exec_fault = fault_next;
                @(negedge clk);
                exec_done = 1'b0; exec_fault = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v, w, dat, exp_st;
        int r0, e0;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) begin
            core_regs[i] = (i * 32'h9E3779B9) ^ 32'h1234;
            exp_regs[i]  = core_regs[i];
        end
        repeat (3) @(negedge clk);
        chk("R1 no request in reset", {31'b0, reg_req_valid}, 0);
        rst_n = 1'b1;

        // R1 reset state
        host_rd(5'd0, v); chk("R1 status after reset", v, 32'h0110_0000);
        host_rd(5'd1, v); chk("R1 command readback", v, 0);
        host_rd(5'd2, v); chk("R1 data word", v, 0);
        host_rd(5'd21, v); chk("R1 slot 5", v, 0);
        chk("R1 run pulse idle", {31'b0, exec_start}, 0);

        // R11 slots
        for (int i = 0; i < 16; i++) host_wr(5'(16 + i), 32'hC0DE_0000 + i * 3);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); slot_idx = 4'(i);
            #1 chk("R11 core slot read", slot_data, 32'hC0DE_0000 + i * 3);
            host_rd(5'(16 + i), v); chk("R11 host slot read", v, 32'hC0DE_0000 + i * 3);
        end

        // R12 no-op command
        r0 = n_req; e0 = n_exec;
        host_wr(5'd1, mk(0, 2, 0, 0, 0, 0, 16'h1003));
        host_rd(5'd0, v);
        chk("R12 no busy, no error", v, 32'h0110_0000);
        chk("R12 nothing issued", n_req - r0 + n_exec - e0, 0);

        // R9 writes while busy, R6 busy during long run
        host_wr(5'd2, 32'h1111_2222);
        exec_delay = 25; fault_next = 1'b0;
        r0 = n_req; e0 = n_exec;
        host_wr(5'd1, mk(0, 2, 0, 1, 0, 0, 16'h1000));
        repeat (4) @(negedge clk);
        host_rd(5'd0, v); chk("R6 busy during run", {31'b0, v[8]}, 1);
        host_wr(5'd2, 32'hBAD0_BAD0);
        host_wr(5'd16, 32'hBAD0_BAD0);
        host_wr(5'd1, mk(0, 2, 0, 0, 1, 0, 16'h1001));
        wait_idle();
        host_rd(5'd0, v); chk("R9 busy error", v[2:0], 1);
        host_rd(5'd2, v); chk("R9 data write ignored", v, 32'h1111_2222);
        host_rd(5'd16, v); chk("R9 slot write ignored", v, 32'hC0DE_0000);
        chk("R9 no request issued", n_req - r0, 0);
        chk("R6 exactly one run pulse", n_exec - e0, 1);

        // R10 sticky error
        exec_delay = 1;
        r0 = n_req;
        host_wr(5'd1, mk(0, 2, 0, 0, 1, 0, 16'h1002));
        repeat (6) @(negedge clk);
        chk("R10 command ignored on error", n_req - r0, 0);
        host_wr(5'd0, 32'h2);
        host_rd(5'd0, v); chk("R10 partial clear keeps bit0", v[2:0], 1);
        host_wr(5'd0, 32'h1);
        host_rd(5'd0, v); chk("R10 cleared", v[2:0], 0);

        // R7 size ignored without transfer
        e0 = n_exec;
        host_wr(5'd1, mk(0, 3, 0, 1, 0, 0, 16'h1000));
        wait_idle();
        host_rd(5'd0, v); chk("R7 size ignored when no transfer", v[2:0], 0);
        chk("R7 run still happens", n_exec - e0, 1);

        // R6 fault
        fault_next = 1'b1;
        host_wr(5'd1, mk(0, 2, 0, 1, 0, 0, 16'h1000));
        wait_idle();
        host_rd(5'd0, v); chk("R6 fault error", v[2:0], 5);
        host_wr(5'd0, 32'h7);

        // random commands
        for (int it = 0; it < 80; it++) begin
            logic [7:0]  kind;
            logic [2:0]  size, exp_err;
            logic        ai, run, xf, wbit, halt, flt, ok;
            logic [15:0] rn, exp_rn;
            logic [31:0] exp_dat;
            kind = ($urandom % 10 == 0) ? 8'(1 + $urandom % 3) : 8'd0;
            size = ($urandom % 8 == 0) ? 3'd3 : 3'd2;
            ai = 1'($urandom); run = ($urandom % 3 == 0); xf = ($urandom % 4 != 0);
            wbit = 1'($urandom); halt = ($urandom % 10 != 0); flt = ($urandom % 4 == 0);
            rn = ($urandom % 2) ? 16'h1000 + 16'($urandom % 32) : 16'h0340 + 16'($urandom % 8);
            dat = $urandom;
            exec_delay = $urandom % 5;

            // prediction
            ok = 1'b0; exp_dat = dat; exp_rn = rn;
            if (kind != 0 || (xf && size != 3'd2)) exp_err = 3'd2;
            else if (!halt) exp_err = 3'd4;
            else begin
                ok = 1'b1; exp_err = 3'd0;
                if (xf) begin
                    if (wbit) exp_regs[rn[7:0]] = dat;
                    else exp_dat = exp_regs[rn[7:0]];
                    if (ai) exp_rn = rn + 16'd1;
                end
                if (run && flt) exp_err = 3'd5;
            end

            host_wr(5'd0, 32'h7);
            host_wr(5'd2, dat);
            core_halted = halt; fault_next = flt;
            r0 = n_req; e0 = n_exec;
            host_wr(5'd1, mk(kind, size, ai, run, xf, wbit, rn));
            wait_idle();
            core_halted = 1'b1;

            exp_st = 32'h0110_0000 | 32'(exp_err);
            host_rd(5'd0, v);
            if (exp_err == 2) chk("R7 unsupported", v, exp_st);
            else if (exp_err == 4) chk("R8 not halted", v, exp_st);
            else chk("R6 status after command", v, exp_st);
            chk("R2 request count", n_req - r0, (ok && xf) ? 1 : 0);
            chk("R6 run pulse count", n_exec - e0, (ok && run) ? 1 : 0);
            if (ok && xf) begin
                chk("R2 request fields", {15'b0, last_wr, last_regno}, {15'b0, wbit, rn});
                if (wbit) begin
                    chk("R3 write data", last_wdata, dat);
                    chk("R3 core register written", core_regs[rn[7:0]], exp_regs[rn[7:0]]);
                end
            end
            host_rd(5'd2, w);
            if (wbit) chk("R3 data word kept", w, exp_dat);
            else chk("R2 read result", w, exp_dat);
            host_rd(5'd1, w);
            chk("R5 command readback", w, mk(kind, size, ai, run, xf, wbit, exp_rn));
        end

        summary();
    end

endmodule